// File: doc/BRIEF.md
# PTP system time counter

This block keeps a free-running precision time value made of a 32-bit seconds count and a nanoseconds count. The nanoseconds count wraps at one billion and carries into seconds. Counting advances in one of two ways. In coarse mode the time steps on every enabled clock. In fine mode a 32-bit phase accumulator adds an addend on every clock, and the time steps only when the accumulator overflows. A step adds a whole-nanosecond increment plus the carry from an 8-bit fractional-nanosecond accumulator.

Software drives the block through a small register write/read port. It stages a seconds value, a nanoseconds value, an addend and the increments. It then starts one of three operations with a self-clearing bit in the control register: load absolute time, add or subtract an offset, or transfer the staged addend into the accumulator. The nominal addend is (50,000,000 << 32) / f_ref. Frequency trim rewrites the staged addend and reloads it while the counter runs.

Top module: `ptp_systime`

## Requirements
- R1: After reset, sec_o and ns_o are 0, and reading the control register (address 0) returns 0.
- R2: With the enable bit set (control bit 0) and the fine bit clear (control bit 1), every clock adds the sub-second increment (address 4, bits 7:0) to the nanoseconds count. At 1,000,000,000 the nanoseconds count wraps, and the amount over the limit is kept while seconds go up by 1. With the enable bit clear, the time holds.
- R3: With the fine bit set, the addend is added to a 32-bit accumulator on every enabled clock. The time steps only on a clock whose addition carries out of 32 bits. After an addend load and m enabled clocks, the number of steps is floor(m*addend/2^32).
- R4: Writing control with the init bit (bit 2) set copies the seconds update register (address 1) and the nanoseconds update register (address 2, bits 29:0) into the time counter. The load happens on the clock after the write, and the fractional accumulator is cleared at the same time. The init bit reads back as 1 for exactly that one cycle and then reads 0.
- R5: Writing control with the update bit (bit 3) set, while the subtract flag (address 2, bit 31) is clear, adds the update registers to the current time. A nanosecond carry goes into seconds.
- R6: With the subtract flag set, an update subtracts an offset of S seconds and N nanoseconds. The seconds field must then hold 0xFFFFFFFF-(S-1), or 0 when S is 0, and the nanoseconds field must hold 1,000,000,000-N. A borrow keeps the nanoseconds in range, and the seconds wrap modulo 2^32.
- R7: Writing control with the addend-load bit (bit 4) set transfers the staged addend (address 3) into the accumulator and clears the accumulator. Until that load, a write to the staged addend has no effect on counting.
- R8: A control write that requests an operation while another operation is still pending starts no operation. Its enable and fine bits still take effect.
- R9: The sub-nanosecond increment (address 4, bits 15:8) is added to an 8-bit fraction on every step. Each carry out of the fraction adds 1 extra nanosecond to that step.
- R10: Reading address 5 with rd_en_i returns the live nanoseconds and latches the live seconds. Reading address 6 then returns the latched seconds, even after the live seconds have moved on.
- R11: The seconds count wraps from 0xFFFFFFFF to 0 when nanoseconds roll over.
- R12: When one control write sets several operation bits, only the highest-priority operation runs. Init wins over update, and update wins over addend load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_en_i | input | 1 | Read strobe; a strobed read of address 5 latches seconds |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Read data for rd_addr_i, combinational |
| sec_o | output | 32 | Live seconds |
| ns_o | output | 30 | Live nanoseconds |

## Verification
The range assertion on the nanoseconds count relies on two software rules. Absolute loads and add offsets must carry a nanoseconds field below one billion. A subtract offset may carry at most one billion, as its complement encoding produces. The bench builds every load and offset within these bounds, and it encodes subtractions exactly as R6 states. The sub-second increment is likewise kept far below the rollover limit, so one wrap per step is enough. The assertions on the self-clearing operations assume nothing about write timing. For that reason the bench also issues back-to-back operation writes on purpose.

// File: rtl/ptp_systime_pkg.sv
package ptp_systime_pkg;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_CTRL     = 3'd0,
    REG_SEC_UPD  = 3'd1,
    REG_NS_UPD   = 3'd2,
    REG_ADDEND   = 3'd3,
    REG_INCR     = 3'd4,
    REG_LIVE_NS  = 3'd5,
    REG_SNAP_SEC = 3'd6
  } reg_addr_e;

  localparam int CTRL_EN    = 0;
  localparam int CTRL_FINE  = 1;
  localparam int CTRL_INIT  = 2;
  localparam int CTRL_UPD   = 3;
  localparam int CTRL_ADDLD = 4;
  localparam int NS_SUB_BIT = 31;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_INIT,
    OP_UPDATE,
    OP_ADDEND
  } op_e;
endpackage

// File: rtl/ptp_regs.sv
module ptp_regs
  import ptp_systime_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int NS_W   = 30,
  parameter int ACC_W  = 32,
  parameter int INC_W  = 8,
  parameter int FRAC_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [REG_ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  rd_en_i,
  input  logic [REG_ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0]     rd_data_o,
  input  logic [SEC_W-1:0]      sec_i,
  input  logic [NS_W-1:0]       ns_i,
  output logic                  en_o,
  output logic                  fine_o,
  output op_e                   op_o,
  output logic [SEC_W-1:0]      sec_upd_o,
  output logic [NS_W-1:0]       ns_upd_o,
  output logic                  sub_o,
  output logic [ACC_W-1:0]      addend_o,
  output logic [INC_W-1:0]      ssinc_o,
  output logic [FRAC_W-1:0]     snsinc_o
);
  logic             ctrl_wr;
  op_e              op_q, op_d;
  logic [SEC_W-1:0] snap_q;
  logic             snap_rd;

  assign ctrl_wr = wr_en_i && (reg_addr_e'(wr_addr_i) == REG_CTRL);
  assign snap_rd = rd_en_i && (reg_addr_e'(rd_addr_i) == REG_LIVE_NS);

  // one operation in flight; requests during it are dropped
  always_comb begin
    op_d = OP_NONE;
    if (op_q == OP_NONE && ctrl_wr) begin
      if (wr_data_i[CTRL_INIT])       op_d = OP_INIT;
      else if (wr_data_i[CTRL_UPD])   op_d = OP_UPDATE;
      else if (wr_data_i[CTRL_ADDLD]) op_d = OP_ADDEND;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= OP_NONE;
      en_o      <= 1'b0;
      fine_o    <= 1'b0;
      sec_upd_o <= '0;
      ns_upd_o  <= '0;
      sub_o     <= 1'b0;
      addend_o  <= '0;
      ssinc_o   <= '0;
      snsinc_o  <= '0;
      snap_q    <= '0;
    end else begin
      op_q <= op_d;
      if (snap_rd) snap_q <= sec_i;
      if (wr_en_i) begin
        case (reg_addr_e'(wr_addr_i))
          REG_CTRL: begin
            en_o   <= wr_data_i[CTRL_EN];
            fine_o <= wr_data_i[CTRL_FINE];
          end
          REG_SEC_UPD: sec_upd_o <= wr_data_i[SEC_W-1:0];
          REG_NS_UPD: begin
            ns_upd_o <= wr_data_i[NS_W-1:0];
            sub_o    <= wr_data_i[NS_SUB_BIT];
          end
          REG_ADDEND: addend_o <= wr_data_i[ACC_W-1:0];
          REG_INCR: begin
            ssinc_o  <= wr_data_i[INC_W-1:0];
            snsinc_o <= wr_data_i[INC_W +: FRAC_W];
          end
          default: ;
        endcase
      end
    end
  end

  assign op_o = op_q;

  always_comb begin
    rd_data_o = '0;
    case (reg_addr_e'(rd_addr_i))
      REG_CTRL: begin
        rd_data_o[CTRL_EN]    = en_o;
        rd_data_o[CTRL_FINE]  = fine_o;
        rd_data_o[CTRL_INIT]  = (op_q == OP_INIT);
        rd_data_o[CTRL_UPD]   = (op_q == OP_UPDATE);
        rd_data_o[CTRL_ADDLD] = (op_q == OP_ADDEND);
      end
      REG_SEC_UPD: rd_data_o = DATA_W'(sec_upd_o);
      REG_NS_UPD: begin
        rd_data_o             = DATA_W'(ns_upd_o);
        rd_data_o[NS_SUB_BIT] = sub_o;
      end
      REG_ADDEND:   rd_data_o = DATA_W'(addend_o);
      REG_INCR:     rd_data_o = DATA_W'({snsinc_o, ssinc_o});
      REG_LIVE_NS:  rd_data_o = DATA_W'(ns_i);
      REG_SNAP_SEC: rd_data_o = DATA_W'(snap_q);
      default: ;
    endcase
  end

  AST_OP_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q != OP_NONE) |=> (op_q == OP_NONE)); // R4
  AST_OP_BUSY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q != OP_NONE && ctrl_wr) |=> (op_q == OP_NONE)); // R8
  AST_INIT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_NONE && ctrl_wr && wr_data_i[CTRL_INIT]) |=> (op_q == OP_INIT)); // R12
  AST_SNAP_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_rd |=> (snap_q == $past(sec_i))); // R10
endmodule

// File: rtl/ptp_rate_gen.sv
module ptp_rate_gen #(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fine_i,
  input  logic             ld_i,
  input  logic [ACC_W-1:0] addend_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] addend_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   acc_sum;

  assign acc_sum = {1'b0, acc_q} + {1'b0, addend_q};
  assign tick_o  = en_i && (fine_i ? acc_sum[ACC_W] : 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addend_q <= '0;
      acc_q    <= '0;
    end else if (ld_i) begin
      addend_q <= addend_i;
      acc_q    <= '0;
    end else if (en_i && fine_i) begin
      acc_q <= acc_sum[ACC_W-1:0];
    end
  end

  AST_ACC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (acc_q == '0)); // R7
  AST_ACC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !(en_i && fine_i)) |=> $stable(acc_q)); // R3
endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core
  import ptp_systime_pkg::*;
#(
  parameter int SEC_W    = 32,
  parameter int NS_W     = 30,
  parameter int INC_W    = 8,
  parameter int FRAC_W   = 8,
  parameter int ROLLOVER = 1000000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  op_e               op_i,
  input  logic [SEC_W-1:0]  sec_upd_i,
  input  logic [NS_W-1:0]   ns_upd_i,
  input  logic              sub_i,
  input  logic [INC_W-1:0]  ssinc_i,
  input  logic [FRAC_W-1:0] snsinc_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [NS_W-1:0]   ns_o
);
  localparam int SUM_W = NS_W + 2;
  localparam logic [SUM_W-1:0] ROLL = SUM_W'(ROLLOVER);

  logic [SEC_W-1:0]  sec_q;
  logic [NS_W-1:0]   ns_q;
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W:0]   frac_sum;
  logic [SUM_W-1:0]  adv_sum, upd_sum;
  logic              adv_wrap, upd_carry;

  assign frac_sum  = {1'b0, frac_q} + {1'b0, snsinc_i};
  assign adv_sum   = SUM_W'(ns_q) + SUM_W'(ssinc_i) + SUM_W'(frac_sum[FRAC_W]);
  assign adv_wrap  = adv_sum >= ROLL;
  assign upd_sum   = SUM_W'(ns_q) + SUM_W'(ns_upd_i);
  assign upd_carry = upd_sum >= ROLL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= '0;
      ns_q   <= '0;
      frac_q <= '0;
    end else begin
      case (op_i)
        OP_INIT: begin
          sec_q  <= sec_upd_i;
          ns_q   <= ns_upd_i;
          frac_q <= '0;
        end
        OP_UPDATE: begin
          // subtract arrives complemented: the extra second is removed here
          sec_q <= sec_q + sec_upd_i + SEC_W'(upd_carry) - SEC_W'(sub_i);
          ns_q  <= NS_W'(upd_carry ? upd_sum - ROLL : upd_sum);
        end
        default: begin
          if (tick_i) begin
            frac_q <= frac_sum[FRAC_W-1:0];
            ns_q   <= NS_W'(adv_wrap ? adv_sum - ROLL : adv_sum);
            if (adv_wrap) sec_q <= sec_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign sec_o = sec_q;
  assign ns_o  = ns_q;

  AST_NS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SUM_W'(ns_q) < ROLL)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && op_i == OP_NONE) |=> ($stable(sec_q) && $stable(ns_q))); // R2
  AST_INIT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_INIT) |=> (sec_q == $past(sec_upd_i) && ns_q == $past(ns_upd_i))); // R4
  AST_SEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && op_i == OP_NONE) |=> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + 1'b1)); // R11
endmodule

// File: rtl/ptp_systime.sv
module ptp_systime
  import ptp_systime_pkg::*;
#(
  parameter int SEC_W    = 32,
  parameter int NS_W     = 30,
  parameter int ACC_W    = 32,
  parameter int INC_W    = 8,
  parameter int FRAC_W   = 8,
  parameter int DATA_W   = 32,
  parameter int ROLLOVER = 1000000000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [REG_ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  rd_en_i,
  input  logic [REG_ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic [SEC_W-1:0]      sec_o,
  output logic [NS_W-1:0]       ns_o
);
  logic              en, fine, sub, tick;
  op_e               op;
  logic [SEC_W-1:0]  sec_upd;
  logic [NS_W-1:0]   ns_upd;
  logic [ACC_W-1:0]  addend;
  logic [INC_W-1:0]  ssinc;
  logic [FRAC_W-1:0] snsinc;

  ptp_regs #(
    .SEC_W(SEC_W), .NS_W(NS_W), .ACC_W(ACC_W),
    .INC_W(INC_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_en_i, .rd_addr_i, .rd_data_o,
    .sec_i(sec_o), .ns_i(ns_o),
    .en_o(en), .fine_o(fine), .op_o(op),
    .sec_upd_o(sec_upd), .ns_upd_o(ns_upd), .sub_o(sub),
    .addend_o(addend), .ssinc_o(ssinc), .snsinc_o(snsinc)
  );

  ptp_rate_gen #(.ACC_W(ACC_W)) u_rate (
    .clk_i, .rst_ni,
    .en_i(en), .fine_i(fine), .ld_i(op == OP_ADDEND),
    .addend_i(addend), .tick_o(tick)
  );

  ptp_time_core #(
    .SEC_W(SEC_W), .NS_W(NS_W), .INC_W(INC_W),
    .FRAC_W(FRAC_W), .ROLLOVER(ROLLOVER)
  ) u_core (
    .clk_i, .rst_ni, .tick_i(tick), .op_i(op),
    .sec_upd_i(sec_upd), .ns_upd_i(ns_upd), .sub_i(sub),
    .ssinc_i(ssinc), .snsinc_i(snsinc),
    .sec_o, .ns_o
  );
endmodule

// File: tb/ptp_systime_bench.sv
`timescale 1ns/1ps
module ptp_systime_bench;
  localparam logic [63:0] NSPS = 64'd1000000000;
  localparam logic [63:0] MODV = 64'd4294967296 * NSPS;
  localparam logic [2:0] A_CTRL = 3'd0, A_SEC = 3'd1, A_NS = 3'd2, A_ADD = 3'd3,
                         A_INC = 3'd4, A_LNS = 3'd5, A_SNAP = 3'd6;
  localparam logic [31:0] B_EN = 32'h1, B_FINE = 32'h2, B_INIT = 32'h4,
                          B_UPD = 32'h8, B_ALD = 32'h10, B_SUB = 32'h8000_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, sec;
  logic [29:0] ns;
  int          vectors = 0, fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  ptp_systime u_ptp_systime (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .sec_o(sec), .ns_o(ns)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_time(input string req, input logic [63:0] es, input logic [63:0] en);
    chk(req, {sec, 2'b00, ns}, {es[31:0], 2'b00, en[29:0]});
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic op_wr(input logic [31:0] d);
    wr(A_CTRL, d); @(negedge clk);
  endtask

  task automatic set_time(input logic [31:0] s, input logic [29:0] n);
    wr(A_SEC, s); wr(A_NS, {2'b00, n}); op_wr(B_INIT);
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] base, off, res, es, en;
    logic [31:0] s0;
    logic [31:0] bsec [3] = '{32'd0, 32'd7, 32'hFFFF_FFFF};
    logic [29:0] bns  [4] = '{30'd0, 30'd1, 30'd500000000, 30'd999999999};
    logic [31:0] osec [3] = '{32'd0, 32'd1, 32'hFFFF_FFFF};
    logic [29:0] ons  [4] = '{30'd0, 30'd1, 30'd400000000, 30'd999999999};
    logic [31:0] incs [3] = '{32'd1, 32'd7, 32'd255};
    logic [31:0] adds [5] = '{32'h8000_0000, 32'h4000_0000, 32'h4000_0001,
                               32'hFFFF_FFFF, 32'h1234_5678};
    logic [31:0] sns  [2] = '{32'd64, 32'd255};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_addr = A_CTRL; #1;
    chk_time("R1 reset time", 0, 0);
    chk("R1 reset ctrl", rd_data, 0);

    // R2 coarse counting sweep
    foreach (incs[k]) begin
      wr(A_INC, incs[k]);
      set_time(32'd3, 30'd999999950);
      wr(A_CTRL, B_EN);
      for (int i = 1; i <= 12; i++) begin
        @(negedge clk); #1;
        en = 64'd999999950 + 64'(incs[k]) * 64'(i);
        es = 3;
        if (en >= NSPS) begin en -= NSPS; es = 4; end
        chk_time("R2 coarse step", es, en);
      end
      wr(A_CTRL, 32'd0);
      #1; es = 64'(sec); en = 64'(ns);
      wait_n(10); #1;
      chk_time("R2 hold when disabled", es, en);
    end

    // R9 fractional increment
    foreach (sns[k]) begin
      wr(A_INC, (sns[k] << 8) | 32'd3);
      set_time(32'd0, 30'd100);
      wr(A_CTRL, B_EN);
      for (int i = 1; i <= 10; i++) begin
        @(negedge clk); #1;
        chk_time("R9 sub-ns carry", 0, 64'd100 + 64'd3 * 64'(i) + (64'(sns[k]) * 64'(i)) / 256);
      end
      wr(A_CTRL, 32'd0);
    end

    // R11 seconds wrap
    wr(A_INC, 32'd5);
    set_time(32'hFFFF_FFFF, 30'd999999990);
    wr(A_CTRL, B_EN);
    @(negedge clk); #1;
    chk_time("R11 before wrap", 64'hFFFF_FFFF, 64'd999999995);
    @(negedge clk); #1;
    chk_time("R11 seconds wrap", 0, 0);
    wr(A_CTRL, 32'd0);

    // R4 init readback and load timing
    wr(A_SEC, 32'd42); wr(A_NS, 32'd12345);
    wr(A_CTRL, B_INIT);
    rd_addr = A_CTRL; #1;
    chk("R4 init bit set", rd_data[4:2], 3'b001);
    @(negedge clk); #1;
    chk("R4 init bit cleared", rd_data[4:2], 3'b000);
    chk_time("R4 loaded", 42, 12345);

    // R5 / R6 add and subtract sweep
    foreach (bsec[a]) foreach (bns[b]) foreach (osec[c]) foreach (ons[d]) begin
      base = 64'(bsec[a]) * NSPS + 64'(bns[b]);
      off  = 64'(osec[c]) * NSPS + 64'(ons[d]);
      for (int sb = 0; sb < 2; sb++) begin
        set_time(bsec[a], bns[b]);
        if (sb == 0) begin
          wr(A_SEC, osec[c]);
          wr(A_NS, {2'b00, ons[d]});
          res = (base + off) % MODV;
        end else begin
          wr(A_SEC, (osec[c] == 0) ? 32'd0 : 32'hFFFF_FFFF - (osec[c] - 32'd1));
          wr(A_NS, B_SUB | (32'd1000000000 - 32'(ons[d])));
          res = (base + MODV - off) % MODV;
        end
        op_wr(B_UPD);
        #1;
        chk_time((sb == 0) ? "R5 add offset" : "R6 subtract offset", res / NSPS, res % NSPS);
      end
    end

    // R12 priority within one write
    wr(A_SEC, 32'd9); wr(A_NS, 32'd777);
    wr(A_CTRL, B_INIT | B_UPD | B_ALD);
    rd_addr = A_CTRL; #1;
    chk("R12 only init pending", rd_data[4:2], 3'b001);
    @(negedge clk); #1;
    chk_time("R12 init result", 9, 777);

    // R8 back-to-back requests
    wr(A_SEC, 32'd20); wr(A_NS, 32'd300);
    @(negedge clk); wr_en = 1'b1; wr_addr = A_CTRL; wr_data = B_INIT;
    @(negedge clk); wr_data = B_UPD;
    @(negedge clk); wr_en = 1'b0;
    rd_addr = A_CTRL; #1;
    chk("R8 second request dropped", rd_data[4:2], 3'b000);
    @(negedge clk); #1;
    chk_time("R8 time after dropped update", 20, 300);

    // R7 staged addend inert until loaded
    wr(A_INC, 32'd1);
    wr(A_ADD, 32'd0);
    op_wr(B_FINE | B_ALD);
    wr(A_ADD, 32'h8000_0000);
    set_time(32'd0, 30'd0);
    wr(A_CTRL, B_EN | B_FINE);
    wait_n(20); #1;
    chk_time("R7 staged addend inert", 0, 0);
    wr(A_CTRL, B_FINE);

    // R3 fine mode sweep
    foreach (adds[k]) begin
      wr(A_ADD, adds[k]);
      op_wr(B_FINE | B_ALD);
      set_time(32'd1, 30'd1000);
      wr(A_CTRL, B_EN | B_FINE);
      wait_n(40); #1;
      chk_time("R3 R7 fine steps", 1, 64'd1000 + (64'd40 * 64'(adds[k])) / 64'd4294967296);
      wr(A_CTRL, B_FINE);
    end

    // R10 coherent snapshot
    wr(A_INC, 32'd200);
    set_time(32'd5, 30'd999998000);
    wr(A_CTRL, B_EN);
    rd_addr = A_LNS; rd_en = 1'b1; #1;
    s0 = sec;
    chk("R10 live ns read", rd_data, 32'(ns));
    @(negedge clk); rd_en = 1'b0;
    wait_n(20);
    rd_addr = A_SNAP; #1;
    chk("R10 snapshot seconds", rd_data, s0);
    chk("R10 live seconds moved", sec, s0 + 32'd1);
    wr(A_CTRL, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule